// File: doc/BRIEF.md
# Isochronous Dual-Buffer Endpoint Engine

This block is the bus-side data mover for one isochronous endpoint that owns two buffers in a shared byte memory, called X and Y. Each buffer has a base address, a size in bytes, and a handoff word made of a NACK flag and a sample count. The engine picks which buffer to use from bit 0 of the current bus frame number. Frames with the bit at 0 use X and frames with the bit at 1 use Y. The local consumer works on the other buffer in the same frame.

In the OUT direction, the host's data bytes arrive as a simple byte stream with start and end markers. The engine stores them in the selected buffer and never writes past that buffer's size. When the packet ends, it records how many whole samples it kept and sets the NACK flag. Bytes beyond the buffer size raise a sticky overflow flag. In the IN direction, an IN token makes the engine check the selected buffer's NACK flag. If the flag is clear, the engine streams count times bytes-per-sample bytes out of memory and then sets the flag. If the flag is set, it sends only a zero-length-packet marker. The engine raises no interrupt. The local consumer (a DMA or a processor) hands buffers back and forth by writing the handoff word through a small local port.

Top module: `iso_dualbuf_engine`

## Requirements
- R1: While reset is held, both NACK flags take the value of `cfg_dir_in`, both counts are 0, `ovf_flag` is 0, and `tx_valid` and `tx_zlp` are 0.
- R2: An OUT byte with index i in its packet is written to address base+i of the selected buffer. The buffer is X if `frame_num_lsb` was 0 on the packet's first byte and Y if it was 1. The other buffer's handoff word is left alone.
- R3: In the cycle after the last OUT byte, the selected buffer's NACK flag is 1 and its count equals the bytes stored divided by bytes-per-sample, rounded down. `cfg_bps` codes 0, 1, 2 and 3 mean 1, 2, 3 and 4 bytes per sample.
- R4: OUT bytes at an index at or above the buffer size are not written. They set `ovf_flag`, which stays at 1 until `ovf_clr`.
- R5: An IN token on a buffer whose NACK flag is 0 and whose count is non-zero produces exactly count × bytes-per-sample bytes on `tx_data`. The bytes come from base upward, with `tx_last` on the final byte. Afterwards the NACK flag is 1 and the count is unchanged.
- R6: An IN token on a buffer whose NACK flag is 1, or whose count is 0, produces a one-cycle `tx_zlp` pulse in the cycle after the token. No memory read and no data bytes follow.
- R7: For an IN token, the buffer is chosen by `frame_num_lsb` sampled with the token: 0 selects X and 1 selects Y.
- R8: While `cfg_ep_en` or `cfg_iso_en` is 0, the engine ignores OUT bytes and IN tokens. It does not access memory, produces no output packet, and leaves the handoff words and `ovf_flag` unchanged.
- R9: A `loc_wr` pulse loads `loc_nack` and `loc_count` into the handoff word of buffer `loc_sel` (0 = X, 1 = Y) at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ep_en | input | 1 | Endpoint enable |
| cfg_iso_en | input | 1 | Isochronous mode enable |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_bps | input | 2 | Bytes per sample minus one |
| cfg_x_base | input | ADDR_W | Base address of buffer X |
| cfg_x_size | input | SIZE_W | Size of buffer X in bytes |
| cfg_y_base | input | ADDR_W | Base address of buffer Y |
| cfg_y_size | input | SIZE_W | Size of buffer Y in bytes |
| frame_num_lsb | input | 1 | Bit 0 of the current frame number |
| rx_valid | input | 1 | OUT data byte valid |
| rx_sop | input | 1 | First byte of an OUT packet |
| rx_eop | input | 1 | Last byte of an OUT packet |
| rx_data | input | 8 | OUT data byte |
| in_tok | input | 1 | IN token for this endpoint, one-cycle pulse |
| tx_valid | output | 1 | IN data byte valid |
| tx_last | output | 1 | Final IN data byte |
| tx_zlp | output | 1 | Send a zero-length packet |
| tx_data | output | 8 | IN data byte |
| mem_we | output | 1 | Buffer memory write enable |
| mem_re | output | 1 | Buffer memory read enable (data one cycle later) |
| mem_addr | output | ADDR_W | Buffer memory address |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_rdata | input | 8 | Buffer memory read data |
| loc_wr | input | 1 | Local handoff word write |
| loc_sel | input | 1 | Local write target, 0 = X, 1 = Y |
| loc_nack | input | 1 | NACK value for the local write |
| loc_count | input | SIZE_W | Count value for the local write |
| ovf_clr | input | 1 | Clear the overflow flag |
| x_nack | output | 1 | NACK flag of buffer X |
| x_count | output | SIZE_W | Sample count of buffer X |
| y_nack | output | 1 | NACK flag of buffer Y |
| y_count | output | SIZE_W | Sample count of buffer Y |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is an OUT packet that runs past the buffer end in the middle of a sample. Three things must then agree: the truncated count, the guard byte just above the buffer, and the sticky flag. The stimulus reaches it by drawing random packet lengths of up to twice the buffer size and pairing them with every bytes-per-sample code, including 3. On the IN side, random NACK flags and zero counts are mixed with full buffers, so the null-packet path and the streaming path alternate on both frame parities.

// File: rtl/iso_ep_pkg.sv
`timescale 1ns/1ps
// Shared types for the isochronous dual-buffer endpoint engine.
// Assumes bytes-per-sample is coded as (bytes - 1) in two bits.
package iso_ep_pkg;
    typedef enum logic {BUF_X = 1'b0, BUF_Y = 1'b1} buf_sel_t;
    typedef enum logic {RD_IDLE = 1'b0, RD_SEND = 1'b1} rd_state_t;

    // Convert a bytes-per-sample code into a byte count of 1..4.
    function automatic logic [2:0] bps_bytes(input logic [1:0] code);
        return {1'b0, code} + 3'd1;
    endfunction
endpackage

// File: rtl/ep_count_regs.sv
`timescale 1ns/1ps
// Holds the two handoff words (NACK flag plus sample count), one per buffer.
// An update from the engine takes priority over a local write to the same buffer
// in the same cycle. Assumes the OUT and IN paths never complete in one cycle.
module ep_count_regs
    import iso_ep_pkg::*;
#(
    parameter int SIZE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  nack_init,
    input  logic                  out_done,
    input  buf_sel_t              out_sel,
    input  logic [SIZE_W-1:0]     out_cnt,
    input  logic                  in_done,
    input  buf_sel_t              in_sel,
    input  logic                  loc_wr,
    input  logic                  loc_sel,
    input  logic                  loc_nack,
    input  logic [SIZE_W-1:0]     loc_cnt,
    output logic [1:0]            nack,
    output logic [1:0][SIZE_W-1:0] cnt
);
    for (genvar b = 0; b < 2; b++) begin : g_buf
        localparam buf_sel_t ME = (b == 0) ? BUF_X : BUF_Y;
        logic              nack_r;
        logic [SIZE_W-1:0] cnt_r;
        logic              hit_out, hit_in, hit_loc;

        assign hit_out = out_done && (out_sel == ME);
        assign hit_in  = in_done && (in_sel == ME);
        assign hit_loc = loc_wr && (loc_sel == ME);

        // Update this buffer's handoff word; the engine wins over local writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nack_r <= nack_init;
                cnt_r  <= '0;
            end else if (hit_out) begin
                nack_r <= 1'b1;
                cnt_r  <= out_cnt;
            end else if (hit_in) begin
                nack_r <= 1'b1;
            end else if (hit_loc) begin
                nack_r <= loc_nack;
                cnt_r  <= loc_cnt;
            end
        end

        assign nack[b] = nack_r;
        assign cnt[b]  = cnt_r;
    end
endmodule

// File: rtl/ep_out_writer.sv
`timescale 1ns/1ps
// OUT path: stores received bytes into the buffer picked by the frame LSB,
// clips at the buffer size, counts whole samples and reports packet completion.
// Assumes one byte per cycle at most and a first byte flagged by rx_sop.
module ep_out_writer
    import iso_ep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              frame_lsb,
    input  logic [1:0]        bps_code,
    input  logic [ADDR_W-1:0] x_base,
    input  logic [ADDR_W-1:0] y_base,
    input  logic [SIZE_W-1:0] x_size,
    input  logic [SIZE_W-1:0] y_size,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done,
    output buf_sel_t          done_sel,
    output logic [SIZE_W-1:0] done_cnt,
    output logic              ovf_hit
);
    logic              active_q;
    buf_sel_t          sel_q;
    logic [SIZE_W-1:0] idx_q, samp_q;
    logic [1:0]        sub_q;

    logic              take, fits, sample_full;
    buf_sel_t          sel_c;
    logic [SIZE_W-1:0] idx_c, samp_c, samp_n, lim_c;
    logic [1:0]        sub_c, sub_n;
    logic [ADDR_W-1:0] base_c;

    // Decide what the current byte does: store, overflow, and/or finish the packet.
    always_comb begin
        take        = go && rx_valid && (rx_sop || active_q);
        sel_c       = rx_sop ? buf_sel_t'(frame_lsb) : sel_q;
        idx_c       = rx_sop ? '0 : idx_q;
        samp_c      = rx_sop ? '0 : samp_q;
        sub_c       = rx_sop ? 2'd0 : sub_q;
        lim_c       = (sel_c == BUF_X) ? x_size : y_size;
        base_c      = (sel_c == BUF_X) ? x_base : y_base;
        fits        = idx_c < lim_c;
        sample_full = (sub_c == bps_code);
        wr_en       = take && fits;
        wr_addr     = base_c + ADDR_W'(idx_c);
        wr_data     = rx_data;
        sub_n       = sub_c;
        samp_n      = samp_c;
        if (wr_en) begin
            if (sample_full) begin
                sub_n  = 2'd0;
                samp_n = samp_c + SIZE_W'(1);
            end else begin
                sub_n  = sub_c + 2'd1;
            end
        end
        ovf_hit  = take && !fits;
        done     = take && rx_eop;
        done_sel = sel_c;
        done_cnt = samp_n;
    end

    // Track packet progress between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sel_q    <= BUF_X;
            idx_q    <= '0;
            samp_q   <= '0;
            sub_q    <= 2'd0;
        end else if (take) begin
            active_q <= !rx_eop;
            sel_q    <= sel_c;
            idx_q    <= fits ? idx_c + SIZE_W'(1) : idx_c;
            samp_q   <= samp_n;
            sub_q    <= sub_n;
        end
    end
endmodule

// File: rtl/ep_in_reader.sv
`timescale 1ns/1ps
// IN path: on a token, checks the selected buffer's handoff word and either
// flags a zero-length packet or streams count*bytes-per-sample bytes out.
// Assumes a memory with one cycle of read latency; tokens while busy are dropped.
module ep_in_reader
    import iso_ep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              frame_lsb,
    input  logic [1:0]        bps_code,
    input  logic [ADDR_W-1:0] x_base,
    input  logic [ADDR_W-1:0] y_base,
    input  logic              tok,
    input  logic [1:0]        nack,
    input  logic [SIZE_W-1:0] cnt_x,
    input  logic [SIZE_W-1:0] cnt_y,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_zlp,
    output logic              done,
    output buf_sel_t          done_sel
);
    localparam int LEN_W = SIZE_W + 2;

    rd_state_t         state_q;
    buf_sel_t          sel_q;
    logic [LEN_W-1:0]  ptr_q, len_q;
    logic              zlp_q, rv_q, rl_q;

    buf_sel_t          sel_c;
    logic [SIZE_W-1:0] cnt_c;
    logic              nack_c, start, empty, last_c;
    logic [LEN_W-1:0]  len_c;

    // Evaluate the token against the handoff word and drive the read port.
    always_comb begin
        sel_c    = buf_sel_t'(frame_lsb);
        cnt_c    = (sel_c == BUF_X) ? cnt_x : cnt_y;
        nack_c   = (sel_c == BUF_X) ? nack[0] : nack[1];
        len_c    = LEN_W'(cnt_c) * LEN_W'(bps_bytes(bps_code));
        start    = go && tok && (state_q == RD_IDLE);
        empty    = nack_c || (cnt_c == '0);
        rd_en    = (state_q == RD_SEND);
        rd_addr  = ((sel_q == BUF_X) ? x_base : y_base) + ADDR_W'(ptr_q);
        last_c   = rd_en && (ptr_q == len_q - LEN_W'(1));
        done     = last_c || (start && !nack_c && (cnt_c == '0));
        done_sel = rd_en ? sel_q : sel_c;
    end

    // Sequence the reads and align output strobes with the memory latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            sel_q   <= BUF_X;
            ptr_q   <= '0;
            len_q   <= '0;
            zlp_q   <= 1'b0;
            rv_q    <= 1'b0;
            rl_q    <= 1'b0;
        end else begin
            zlp_q <= start && empty;
            rv_q  <= rd_en;
            rl_q  <= last_c;
            case (state_q)
                RD_IDLE: if (start && !empty) begin
                    state_q <= RD_SEND;
                    sel_q   <= sel_c;
                    ptr_q   <= '0;
                    len_q   <= len_c;
                end
                RD_SEND: begin
                    ptr_q <= ptr_q + LEN_W'(1);
                    if (last_c) state_q <= RD_IDLE;
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign tx_valid = rv_q;
    assign tx_last  = rl_q;
    assign tx_zlp   = zlp_q;
endmodule

// File: rtl/iso_dualbuf_engine.sv
`timescale 1ns/1ps
// Top of the isochronous dual-buffer endpoint engine. Routes the OUT writer
// and IN reader onto one memory port, keeps the handoff words and the sticky
// overflow flag. Assumes configuration is stable while packets are in flight.
module iso_dualbuf_engine
    import iso_ep_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ep_en,
    input  logic              cfg_iso_en,
    input  logic              cfg_dir_in,
    input  logic [1:0]        cfg_bps,
    input  logic [ADDR_W-1:0] cfg_x_base,
    input  logic [SIZE_W-1:0] cfg_x_size,
    input  logic [ADDR_W-1:0] cfg_y_base,
    input  logic [SIZE_W-1:0] cfg_y_size,
    input  logic              frame_num_lsb,
    input  logic              rx_valid,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic [7:0]        rx_data,
    input  logic              in_tok,
    output logic              tx_valid,
    output logic              tx_last,
    output logic              tx_zlp,
    output logic [7:0]        tx_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              loc_wr,
    input  logic              loc_sel,
    input  logic              loc_nack,
    input  logic [SIZE_W-1:0] loc_count,
    input  logic              ovf_clr,
    output logic              x_nack,
    output logic [SIZE_W-1:0] x_count,
    output logic              y_nack,
    output logic [SIZE_W-1:0] y_count,
    output logic              ovf_flag
);
    logic                    ep_live, go_out, go_in;
    logic                    w_en, r_en, out_done, in_done, ovf_hit;
    logic [ADDR_W-1:0]       w_addr, r_addr;
    logic [7:0]              w_data;
    buf_sel_t                out_sel, in_sel;
    logic [SIZE_W-1:0]       out_cnt;
    logic [1:0]              nack;
    logic [1:0][SIZE_W-1:0]  cnt;
    logic                    ovf_q;

    assign ep_live = cfg_ep_en && cfg_iso_en;
    assign go_out  = ep_live && !cfg_dir_in;
    assign go_in   = ep_live && cfg_dir_in;

    ep_out_writer #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) out_i (
        .clk(clk), .rst_n(rst_n), .go(go_out), .frame_lsb(frame_num_lsb),
        .bps_code(cfg_bps), .x_base(cfg_x_base), .y_base(cfg_y_base),
        .x_size(cfg_x_size), .y_size(cfg_y_size),
        .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_data(rx_data),
        .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
        .done(out_done), .done_sel(out_sel), .done_cnt(out_cnt), .ovf_hit(ovf_hit)
    );

    ep_in_reader #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) in_i (
        .clk(clk), .rst_n(rst_n), .go(go_in), .frame_lsb(frame_num_lsb),
        .bps_code(cfg_bps), .x_base(cfg_x_base), .y_base(cfg_y_base),
        .tok(in_tok), .nack(nack), .cnt_x(cnt[0]), .cnt_y(cnt[1]),
        .rd_en(r_en), .rd_addr(r_addr),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_zlp(tx_zlp),
        .done(in_done), .done_sel(in_sel)
    );

    ep_count_regs #(.SIZE_W(SIZE_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .nack_init(cfg_dir_in),
        .out_done(out_done), .out_sel(out_sel), .out_cnt(out_cnt),
        .in_done(in_done), .in_sel(in_sel),
        .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_nack(loc_nack), .loc_cnt(loc_count),
        .nack(nack), .cnt(cnt)
    );

    // Sticky overflow: a new overflow wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_q <= 1'b0;
        else if (ovf_hit) ovf_q <= 1'b1;
        else if (ovf_clr) ovf_q <= 1'b0;
    end

    assign mem_we    = w_en;
    assign mem_re    = r_en;
    assign mem_addr  = w_en ? w_addr : r_addr;
    assign mem_wdata = w_data;
    assign tx_data   = mem_rdata;
    assign x_nack    = nack[0];
    assign y_nack    = nack[1];
    assign x_count   = cnt[0];
    assign y_count   = cnt[1];
    assign ovf_flag  = ovf_q;
endmodule

// File: rtl/iso_dualbuf_engine_chk.sv
`timescale 1ns/1ps
// Property checker for the endpoint engine, bound to the top by name.
// Assumes configuration changes only while reset is held.
module iso_dualbuf_engine_chk #(
    parameter int ADDR_W = 8,
    parameter int SIZE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ep_en,
    input logic              cfg_iso_en,
    input logic              cfg_dir_in,
    input logic [ADDR_W-1:0] cfg_x_base,
    input logic [SIZE_W-1:0] cfg_x_size,
    input logic [ADDR_W-1:0] cfg_y_base,
    input logic [SIZE_W-1:0] cfg_y_size,
    input logic              rx_valid,
    input logic              rx_eop,
    input logic              in_tok,
    input logic              tx_valid,
    input logic              tx_last,
    input logic              tx_zlp,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              loc_wr,
    input logic              loc_sel,
    input logic              loc_nack,
    input logic              ovf_clr,
    input logic              x_nack,
    input logic              y_nack,
    input logic              ovf_flag
);
    logic [ADDR_W-1:0] off_x, off_y;
    logic              in_x, in_y;
    assign off_x = mem_addr - cfg_x_base;
    assign off_y = mem_addr - cfg_y_base;
    assign in_x  = {{SIZE_W{1'b0}}, off_x} < {{ADDR_W{1'b0}}, cfg_x_size};
    assign in_y  = {{SIZE_W{1'b0}}, off_y} < {{ADDR_W{1'b0}}, cfg_y_size};

    AST_WR_INSIDE_BUF: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (in_x || in_y)); // R4
    AST_WR_ONLY_LIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (cfg_ep_en && cfg_iso_en && !cfg_dir_in)); // R8
    AST_ZLP_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n) tx_zlp |-> (!tx_valid && !mem_re)); // R6
    AST_ZLP_AFTER_TOKEN: assert property (@(posedge clk) disable iff (!rst_n) tx_zlp |-> $past(in_tok)); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_flag && !ovf_clr) |=> ovf_flag); // R4
    AST_LAST_SETS_NACK: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_last) |-> (x_nack || y_nack)); // R5
    AST_OUT_NACK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && $rose(x_nack)) |-> ($past(rx_valid && rx_eop) || $past(loc_wr && !loc_sel && loc_nack))); // R3
endmodule

bind iso_dualbuf_engine iso_dualbuf_engine_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (.*);

// File: tb/iso_dualbuf_engine_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random OUT and IN traffic, with expected
// values from bench functions and a byte memory model with one cycle of read latency.
module iso_dualbuf_engine_tb_top;
    localparam int ADDR_W = 8;
    localparam int SIZE_W = 8;
    localparam int XB = 16, XS = 24, YB = 128, YS = 40;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_ep_en, cfg_iso_en, cfg_dir_in;
    logic [1:0] cfg_bps;
    logic [ADDR_W-1:0] cfg_x_base, cfg_y_base;
    logic [SIZE_W-1:0] cfg_x_size, cfg_y_size;
    logic frame_num_lsb, rx_valid, rx_sop, rx_eop, in_tok;
    logic [7:0] rx_data;
    logic tx_valid, tx_last, tx_zlp;
    logic [7:0] tx_data;
    logic mem_we, mem_re;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic loc_wr, loc_sel, loc_nack, ovf_clr;
    logic [SIZE_W-1:0] loc_count;
    logic x_nack, y_nack, ovf_flag;
    logic [SIZE_W-1:0] x_count, y_count;

    iso_dualbuf_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut_i (.*);

    logic [7:0] ram [0:(1<<ADDR_W)-1];
    logic pl_we;
    logic [ADDR_W-1:0] pl_addr;
    logic [7:0] pl_data;
    int we_cnt = 0, re_cnt = 0;

    // Memory model with bench preload port and access counters.
    always @(posedge clk) begin
        if (pl_we) ram[pl_addr] <= pl_data;
        if (mem_we) begin ram[mem_addr] <= mem_wdata; we_cnt <= we_cnt + 1; end
        if (mem_re) begin mem_rdata <= ram[mem_addr]; re_cnt <= re_cnt + 1; end
    end

    int n_chk = 0, n_fail = 0;

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] guard(input int a);
        return 8'((a ^ 32'h5A) & 255);
    endfunction

    function automatic logic [7:0] pkt_byte(input int s, input int i);
        return 8'((s * 37 + i * 11 + 5) & 255);
    endfunction

    function automatic int exp_count(input int n, input int size, input int bps);
        int stored;
        stored = (n < size) ? n : size;
        return stored / bps;
    endfunction

    task automatic loc_write(input logic sel, input logic nk, input int c);
        @(negedge clk);
        loc_wr = 1'b1; loc_sel = sel; loc_nack = nk; loc_count = SIZE_W'(c);
        @(negedge clk);
        loc_wr = 1'b0;
    endtask

    task automatic clear_ovf();
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
    endtask

    task automatic do_reset(input logic dir);
        @(negedge clk);
        rst_n = 1'b0; cfg_dir_in = dir;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_out(input int n, input logic fb, input int s);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_num_lsb = (i == 0) ? fb : ~fb;
            rx_valid = 1'b1; rx_sop = (i == 0); rx_eop = (i == n - 1);
            rx_data = pkt_byte(s, i);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0;
    endtask

    // One OUT packet on an enabled endpoint, with all its consequences checked.
    task automatic out_case(input int n, input logic fb, input int s, input logic [1:0] code);
        int base, size, stored, bad, other_nk;
        cfg_bps = code;
        loc_write(fb, 1'b0, 0);
        clear_ovf();
        other_nk = fb ? int'(x_nack) : int'(y_nack);
        base = fb ? YB : XB;
        size = fb ? YS : XS;
        stored = (n < size) ? n : size;
        send_out(n, fb, s);
        check_eq("R3 nack set", fb ? int'(y_nack) : int'(x_nack), 1);
        check_eq("R3 sample count", fb ? int'(y_count) : int'(x_count), exp_count(n, size, int'(code) + 1));
        check_eq("R4 overflow flag", int'(ovf_flag), (n > size) ? 1 : 0);
        bad = 0;
        for (int i = 0; i < stored; i++) if (ram[base + i] != pkt_byte(s, i)) bad++;
        check_eq("R2 stored bytes mismatches", bad, 0);
        check_eq("R4 guard byte", int'(ram[base + size]), int'(guard(base + size)));
        check_eq("R2 other buffer nack", fb ? int'(x_nack) : int'(y_nack), other_nk);
    endtask

    // Issue an IN token and gather what comes out over a fixed window.
    task automatic in_run(input logic fb, input int base, input int win,
                          output int nbytes, output int zlps, output int lastpos, output int bad);
        @(negedge clk); frame_num_lsb = fb; in_tok = 1'b1;
        @(negedge clk); in_tok = 1'b0; frame_num_lsb = ~fb;
        nbytes = 0; zlps = 0; lastpos = -1; bad = 0;
        for (int c = 0; c < win; c++) begin
            if (tx_zlp) zlps++;
            if (tx_valid) begin
                if (tx_data != ram[base + nbytes]) bad++;
                if (tx_last) lastpos = nbytes;
                nbytes++;
            end
            @(negedge clk);
        end
    endtask

    task automatic in_case(input logic fb, input logic nk, input int c, input logic [1:0] code);
        int base, len, nb, zl, lp, bad, re0;
        logic empty;
        cfg_bps = code;
        loc_write(fb, nk, c);
        base = fb ? YB : XB;
        empty = nk || (c == 0);
        len = empty ? 0 : c * (int'(code) + 1);
        re0 = re_cnt;
        in_run(fb, base, len + 8, nb, zl, lp, bad);
        if (empty) begin
            check_eq("R6 zlp pulses", zl, 1);
            check_eq("R6 data bytes", nb, 0);
            check_eq("R6 memory reads", re_cnt - re0, 0);
        end else begin
            check_eq("R5 byte total", nb, len);
            check_eq("R7 byte data mismatches", bad, 0);
            check_eq("R5 last position", lp, len - 1);
            check_eq("R5 no zlp", zl, 0);
            check_eq("R5 count kept", fb ? int'(y_count) : int'(x_count), c);
        end
        check_eq("R5 nack after token", fb ? int'(y_nack) : int'(x_nack), 1);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int nb, zl, lp, bad, we0, re0;
        void'($urandom(32'd4242));
        rst_n = 1'b0; cfg_ep_en = 1'b1; cfg_iso_en = 1'b1; cfg_dir_in = 1'b0; cfg_bps = 2'd0;
        cfg_x_base = ADDR_W'(XB); cfg_x_size = SIZE_W'(XS);
        cfg_y_base = ADDR_W'(YB); cfg_y_size = SIZE_W'(YS);
        frame_num_lsb = 1'b0; rx_valid = 1'b0; rx_sop = 1'b0; rx_eop = 1'b0; rx_data = 8'd0;
        in_tok = 1'b0; loc_wr = 1'b0; loc_sel = 1'b0; loc_nack = 1'b0; loc_count = '0;
        ovf_clr = 1'b0; pl_we = 1'b0; pl_addr = '0; pl_data = '0;
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            @(negedge clk); pl_we = 1'b1; pl_addr = ADDR_W'(a); pl_data = guard(a);
        end
        @(negedge clk); pl_we = 1'b0;
        do_reset(1'b0);
        check_eq("R1 x nack out-mode", int'(x_nack), 0);
        check_eq("R1 y nack out-mode", int'(y_nack), 0);
        check_eq("R1 counts", int'(x_count) + int'(y_count), 0);
        check_eq("R1 ovf", int'(ovf_flag), 0);
        check_eq("R1 tx idle", int'(tx_valid) + int'(tx_zlp), 0);

        // Directed OUT corners: exact fit, partial sample, overflow, 3-byte samples.
        out_case(XS, 1'b0, 1, 2'd0);
        out_case(7, 1'b1, 2, 2'd1);
        out_case(XS + 5, 1'b0, 3, 2'd2);
        out_case(YS + 1, 1'b1, 4, 2'd3);
        out_case(1, 1'b0, 5, 2'd3);
        // Overflow flag persists until cleared.
        send_out(XS + 2, 1'b0, 6);
        repeat (3) @(negedge clk);
        check_eq("R4 ovf sticky", int'(ovf_flag), 1);
        clear_ovf();
        check_eq("R4 ovf cleared", int'(ovf_flag), 0);

        // Local handoff writes.
        loc_write(1'b0, 1'b1, 9);
        check_eq("R9 x nack", int'(x_nack), 1);
        check_eq("R9 x count", int'(x_count), 9);
        loc_write(1'b1, 1'b0, 3);
        check_eq("R9 y nack", int'(y_nack), 0);
        check_eq("R9 y count", int'(y_count), 3);

        // Disabled endpoint ignores OUT data.
        cfg_ep_en = 1'b0;
        we0 = we_cnt;
        send_out(XS + 4, 1'b1, 7);
        check_eq("R8 no writes when disabled", we_cnt - we0, 0);
        check_eq("R8 y handoff untouched", int'(y_nack) * 256 + int'(y_count), 3);
        check_eq("R8 ovf untouched", int'(ovf_flag), 0);
        cfg_ep_en = 1'b1;

        // Random OUT traffic.
        for (int k = 0; k < 40; k++) begin
            out_case(1 + int'($urandom % 80), 1'($urandom % 2), 10 + k, 2'($urandom % 4));
        end

        // IN direction.
        do_reset(1'b1);
        check_eq("R1 x nack in-mode", int'(x_nack), 1);
        check_eq("R1 y nack in-mode", int'(y_nack), 1);
        in_case(1'b0, 1'b1, 4, 2'd0);
        in_case(1'b0, 1'b0, 6, 2'd1);
        in_case(1'b1, 1'b0, 0, 2'd0);
        in_case(1'b1, 1'b0, YS / 4, 2'd3);
        in_case(1'b0, 1'b0, XS / 3, 2'd2);
        // Frame parity picks the buffer: only Y is ready, token in an X frame sends null.
        loc_write(1'b0, 1'b1, 2);
        loc_write(1'b1, 1'b0, 5);
        cfg_bps = 2'd0;
        in_run(1'b0, XB, 12, nb, zl, lp, bad);
        check_eq("R7 x frame sees x nack", zl, 1);
        check_eq("R7 y untouched", int'(y_nack), 0);
        in_run(1'b1, YB, 14, nb, zl, lp, bad);
        check_eq("R7 y frame sends y", nb, 5);
        // Disabled iso mode ignores tokens.
        loc_write(1'b0, 1'b0, 4);
        cfg_iso_en = 1'b0;
        re0 = re_cnt;
        in_run(1'b0, XB, 12, nb, zl, lp, bad);
        check_eq("R8 no output when iso off", nb + zl, 0);
        check_eq("R8 no reads when iso off", re_cnt - re0, 0);
        check_eq("R8 x nack kept", int'(x_nack), 0);
        cfg_iso_en = 1'b1;

        // Random IN traffic.
        for (int k = 0; k < 40; k++) begin
            logic [1:0] code;
            logic fb;
            int lim;
            code = 2'($urandom % 4);
            fb = 1'($urandom % 2);
            lim = (fb ? YS : XS) / (int'(code) + 1);
            in_case(fb, ($urandom % 4) == 0, int'($urandom % (lim + 1)), code);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule